// File: doc/BRIEF.md
# Branch Resolve Unit

This block looks at one jump-class instruction and settles where execution goes next. It takes the 8-bit opcode, the two register operands, the 32-bit immediate, the 16-bit displacement, the source-register field of the instruction (used here only to tell call kinds apart) and the current program counter. The program counter counts whole 64-bit instruction slots. The block returns whether control transfers, the next program counter, and two marks that flag call and exit instructions for the surrounding pipeline.

The unit is purely combinational. It sits between operand fetch and the PC register of a small in-order core. Two compare widths share one decoder. The opcode's low three bits pick the full 64-bit class (5) or the low-half 32-bit class (6). Every other class passes through as a plain sequential step. Helper calls, the call stack and returns are handled elsewhere. This block only flags them.

Top module: `jump_resolve`

## Requirements
- R1: When opcode[2:0] is 5, the conditional compares use all 64 bits of both operands.
- R2: When opcode[2:0] is 6, the conditional compares use only bits 31:0 of both operands, and signed compares take bit 31 as the sign.
- R3: The condition in opcode[7:4] selects the test. Code 1 is equal, code 5 is not-equal, and code 4 is "bitwise AND of the operands is nonzero".
- R4: Codes 2, 3, 0xa and 0xb are the unsigned tests greater, greater-or-equal, less and less-or-equal.
- R5: Codes 6, 7, 0xc and 0xd are the same four tests on two's-complement values. Opcode 0x7e is therefore a signed greater-or-equal on the low 32 bits of both registers.
- R6: When opcode bit 3 is 1, the second operand is the source register. When it is 0, the second operand is the immediate sign-extended from 32 bits.
- R7: A taken conditional, or a code-0 jump in class 5, yields next PC = PC + 1 + sign-extended 16-bit displacement. An instruction that is not taken yields PC + 1.
- R8: Code 0 in class 6 always jumps to PC + 1 + the 32-bit immediate, and the displacement field is ignored.
- R9: Code 8 in class 5 raises call_o. With a source field of 1 it is taken to PC + 1 + immediate. With any other source field it is not taken and yields PC + 1.
- R10: Code 9 in class 5 raises exit_o and is not taken. Codes 8 and 9 in class 6, codes 0xe and 0xf, and every class other than 5 and 6 raise no flag, are not taken and yield PC + 1.
- R11: Next-PC arithmetic wraps modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 8 | Instruction opcode: condition [7:4], operand select [3], class [2:0] |
| dst_i | input | XLEN | First compare operand (destination register value) |
| src_i | input | XLEN | Source register value |
| imm_i | input | 32 | Immediate field |
| offset_i | input | 16 | Signed displacement field |
| call_kind_i | input | 4 | Source-register field of the instruction; 1 marks a local call |
| pc_i | input | PC_W | Current program counter in instruction slots |
| taken_o | output | 1 | Control transfers to the computed target |
| next_pc_o | output | PC_W | Program counter of the next instruction |
| call_o | output | 1 | Instruction is a call |
| exit_o | output | 1 | Instruction is an exit |

## Verification
The bench targets operands whose upper and lower halves disagree. A design that ignored the class width would take the 64-bit verdict on a 32-bit compare, or the reverse. It also drives values with the sign bit set at bit 31 and at bit 63, against small positives. A design that mixed up signed and unsigned tests, or picked the wrong sign bit, would branch the wrong way on those cases. The 32-bit unconditional jump is given a large displacement alongside a small immediate, so a design that used the wrong field would land far away. Codes 8 and 9 in the 32-bit class, call kinds other than local, and a PC at the top of its range catch stray flags, wrongly taken helper calls and a broken wrap.

// File: rtl/jr_pkg.sv
package jr_pkg;
  localparam logic [2:0] CLS_WIDE   = 3'd5;
  localparam logic [2:0] CLS_NARROW = 3'd6;
  localparam logic [3:0] KIND_LOCAL = 4'd1;

  typedef enum logic [3:0] {
    CC_ALWAYS = 4'h0, CC_EQ  = 4'h1, CC_UGT = 4'h2, CC_UGE = 4'h3,
    CC_ANY    = 4'h4, CC_NE  = 4'h5, CC_SGT = 4'h6, CC_SGE = 4'h7,
    CC_CALL   = 4'h8, CC_RET = 4'h9, CC_ULT = 4'ha, CC_ULE = 4'hb,
    CC_SLT    = 4'hc, CC_SLE = 4'hd, CC_RSV_E = 4'he, CC_RSV_F = 4'hf
  } cond_e;

  typedef enum logic [1:0] {TGT_SEQ, TGT_OFF, TGT_IMM} tgt_e;

  typedef struct packed {
    logic eq;
    logic ugt;
    logic ult;
    logic sgt;
    logic slt;
    logic any;
  } rel_t;
endpackage

// File: rtl/jr_compare.sv
module jr_compare
  import jr_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output rel_t         rel_o
);
  always_comb begin
    rel_o.eq  = (a_i == b_i);
    rel_o.ugt = (a_i > b_i);
    rel_o.ult = (a_i < b_i);
    rel_o.sgt = ($signed(a_i) > $signed(b_i));
    rel_o.slt = ($signed(a_i) < $signed(b_i));
    rel_o.any = |(a_i & b_i);
  end

  always_comb begin
    p_unsigned_trichotomy_r4: assert ($countones({rel_o.eq, rel_o.ugt, rel_o.ult}) == 1)
      else $error("unsigned relations not exclusive");
    p_signed_trichotomy_r5: assert ($countones({rel_o.eq, rel_o.sgt, rel_o.slt}) == 1)
      else $error("signed relations not exclusive");
  end
endmodule

// File: rtl/jr_decode.sv
module jr_decode
  import jr_pkg::*;
(
  input  logic [7:0] opcode_i,
  input  logic [3:0] call_kind_i,
  output logic       narrow_o,
  output cond_e      code_o,
  output logic       cond_en_o,
  output logic       always_o,
  output tgt_e       tgt_o,
  output logic       call_o,
  output logic       exit_o
);
  logic [2:0] cls;
  logic       wide;
  logic       jump_cls;

  assign cls      = opcode_i[2:0];
  assign wide     = (cls == CLS_WIDE);
  assign narrow_o = (cls == CLS_NARROW);
  assign jump_cls = wide | narrow_o;
  assign code_o   = cond_e'(opcode_i[7:4]);

  always_comb begin
    cond_en_o = 1'b0;
    always_o  = 1'b0;
    tgt_o     = TGT_OFF;
    call_o    = 1'b0;
    exit_o    = 1'b0;
    if (jump_cls) begin
      unique case (code_o)
        CC_ALWAYS: begin
          always_o = 1'b1;
          tgt_o    = wide ? TGT_OFF : TGT_IMM;
        end
        CC_EQ, CC_UGT, CC_UGE, CC_ANY, CC_NE, CC_SGT, CC_SGE,
        CC_ULT, CC_ULE, CC_SLT, CC_SLE: cond_en_o = 1'b1;
        CC_CALL: if (wide) begin
          call_o = 1'b1;
          if (call_kind_i == KIND_LOCAL) begin
            always_o = 1'b1;
            tgt_o    = TGT_IMM;
          end
        end
        CC_RET: exit_o = wide;
        default: ;
      endcase
    end
  end

  always_comb begin
    p_kind_exclusive_r10: assert ($countones({cond_en_o, always_o}) <= 1)
      else $error("conditional and unconditional both set");
    p_exit_alone_r10: assert (!exit_o || !(cond_en_o || always_o || call_o))
      else $error("exit combined with another kind");
  end
endmodule

// File: rtl/jr_target.sv
module jr_target
  import jr_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic [15:0]     offset_i,
  input  logic [31:0]     imm_i,
  input  tgt_e            sel_i,
  output logic [PC_W-1:0] next_pc_o
);
  localparam int unsigned EXT_W = (PC_W > 32) ? PC_W : 32;

  logic [EXT_W-1:0] disp;

  always_comb begin
    unique case (sel_i)
      TGT_OFF: disp = EXT_W'(signed'(offset_i));
      TGT_IMM: disp = EXT_W'(signed'(imm_i));
      default: disp = '0;
    endcase
  end

  assign next_pc_o = pc_i + PC_W'(1) + disp[PC_W-1:0];
endmodule

// File: rtl/jump_resolve.sv
module jump_resolve
  import jr_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned PC_W = 32
) (
  input  logic [7:0]      opcode_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [31:0]     imm_i,
  input  logic [15:0]     offset_i,
  input  logic [3:0]      call_kind_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            taken_o,
  output logic [PC_W-1:0] next_pc_o,
  output logic            call_o,
  output logic            exit_o
);
  localparam int unsigned N_WIDTHS = 2;

  logic [XLEN-1:0] opnd_b;
  rel_t            rel [N_WIDTHS];
  rel_t            rel_sel;
  logic            narrow;
  cond_e           code;
  logic            cond_en;
  logic            always_take;
  tgt_e            dec_tgt;
  tgt_e            tgt_sel;
  logic            hit;

  assign opnd_b = opcode_i[3] ? src_i : XLEN'(signed'(imm_i));

  jr_decode u_decode (
    .opcode_i    (opcode_i),
    .call_kind_i (call_kind_i),
    .narrow_o    (narrow),
    .code_o      (code),
    .cond_en_o   (cond_en),
    .always_o    (always_take),
    .tgt_o       (dec_tgt),
    .call_o      (call_o),
    .exit_o      (exit_o)
  );

  // slice 0 compares full width, slice 1 the low 32 bits
  for (genvar g = 0; g < N_WIDTHS; g++) begin : g_cmp
    localparam int unsigned CW = (g == 0) ? XLEN : 32;
    jr_compare #(.W(CW)) u_cmp (
      .a_i   (dst_i[CW-1:0]),
      .b_i   (opnd_b[CW-1:0]),
      .rel_o (rel[g])
    );
  end

  assign rel_sel = narrow ? rel[1] : rel[0];

  always_comb begin
    unique case (code)
      CC_EQ:   hit = rel_sel.eq;
      CC_NE:   hit = !rel_sel.eq;
      CC_ANY:  hit = rel_sel.any;
      CC_UGT:  hit = rel_sel.ugt;
      CC_UGE:  hit = rel_sel.ugt | rel_sel.eq;
      CC_ULT:  hit = rel_sel.ult;
      CC_ULE:  hit = rel_sel.ult | rel_sel.eq;
      CC_SGT:  hit = rel_sel.sgt;
      CC_SGE:  hit = rel_sel.sgt | rel_sel.eq;
      CC_SLT:  hit = rel_sel.slt;
      CC_SLE:  hit = rel_sel.slt | rel_sel.eq;
      default: hit = 1'b0;
    endcase
  end

  assign taken_o = always_take | (cond_en & hit);
  assign tgt_sel = taken_o ? dec_tgt : TGT_SEQ;

  jr_target #(.PC_W(PC_W)) u_target (
    .pc_i      (pc_i),
    .offset_i  (offset_i),
    .imm_i     (imm_i),
    .sel_i     (tgt_sel),
    .next_pc_o (next_pc_o)
  );

  always_comb begin
    p_fallthrough_r7: assert (taken_o || next_pc_o == pc_i + PC_W'(1))
      else $error("untaken instruction left sequential flow");
    p_exit_not_taken_r10: assert (!exit_o || !taken_o)
      else $error("exit marked taken");
    p_call_exit_excl_r9: assert (!(call_o && exit_o))
      else $error("call and exit together");
  end
endmodule

// File: tb/jump_resolve_tb.sv
module jump_resolve_tb;
  logic        clk = 1'b0;
  logic [7:0]  op;
  logic [63:0] d, s;
  logic [31:0] im;
  logic [15:0] of;
  logic [3:0]  k;
  logic [31:0] pc;
  logic        taken, call, ext;
  logic [31:0] npc;
  int n_run = 0;
  int n_fail = 0;

  always #10ns clk = ~clk;

  jump_resolve #(.XLEN(64), .PC_W(32)) u_dut (
    .opcode_i(op), .dst_i(d), .src_i(s), .imm_i(im), .offset_i(of),
    .call_kind_i(k), .pc_i(pc), .taken_o(taken), .next_pc_o(npc),
    .call_o(call), .exit_o(ext)
  );

  function automatic void model(input logic [7:0] o, input logic [63:0] a64, input logic [63:0] s64,
                                input logic [31:0] i32, input logic [15:0] o16, input logic [3:0] kk,
                                input logic [31:0] p, output bit tk, output logic [31:0] np,
                                output bit cl, output bit ex);
    int cls = int'(o[2:0]);
    int code = int'(o[7:4]);
    bit wide = (cls == 5);
    bit nar = (cls == 6);
    logic [63:0] b64 = o[3] ? s64 : {{32{i32[31]}}, i32};
    longint unsigned ua, ub;
    longint sa, sb;
    bit c;
    if (nar) begin
      ua = {32'd0, a64[31:0]}; ub = {32'd0, b64[31:0]};
      sa = longint'(int'(a64[31:0])); sb = longint'(int'(b64[31:0]));
    end else begin
      ua = a64; ub = b64; sa = longint'(a64); sb = longint'(b64);
    end
    tk = 0; cl = 0; ex = 0; c = 0;
    np = p + 32'd1;
    if (wide || nar) begin
      case (code)
        0: begin
          tk = 1;
          np = wide ? p + 32'd1 + {{16{o16[15]}}, o16} : p + 32'd1 + i32;
        end
        8: if (wide) begin
          cl = 1;
          if (kk == 4'd1) begin tk = 1; np = p + 32'd1 + i32; end
        end
        9: if (wide) ex = 1;
        1: c = (ua == ub);
        5: c = (ua != ub);
        4: c = ((ua & ub) != 0);
        2: c = (ua > ub);
        3: c = (ua >= ub);
        10: c = (ua < ub);
        11: c = (ua <= ub);
        6: c = (sa > sb);
        7: c = (sa >= sb);
        12: c = (sa < sb);
        13: c = (sa <= sb);
        default: c = 0;
      endcase
      if (c) begin tk = 1; np = p + 32'd1 + {{16{o16[15]}}, o16}; end
    end
  endfunction

  task automatic apply(input string tag, input logic [7:0] o, input logic [63:0] a, input logic [63:0] b,
                       input logic [31:0] i, input logic [15:0] f, input logic [3:0] kk, input logic [31:0] p);
    bit etk, ecl, eex;
    logic [31:0] enp;
    @(posedge clk);
    op = o; d = a; s = b; im = i; of = f; k = kk; pc = p;
    model(o, a, b, i, f, kk, p, etk, enp, ecl, eex);
    @(negedge clk);
    n_run++;
    if (taken !== etk || npc !== enp || call !== ecl || ext !== eex) begin
      n_fail++;
      $display("FAIL %s op=%h: got taken=%b pc=%h call=%b exit=%b, expected taken=%b pc=%h call=%b exit=%b",
               tag, o, taken, npc, call, ext, etk, enp, ecl, eex);
    end
  endtask

  function automatic string tag_of(input logic [7:0] o);
    if (o[2:0] != 3'd5 && o[2:0] != 3'd6) return "R10";
    case (o[7:4])
      4'h0: return (o[2:0] == 3'd5) ? "R7" : "R8";
      4'h1, 4'h4, 4'h5: return "R3";
      4'h2, 4'h3, 4'ha, 4'hb: return "R4";
      4'h6, 4'h7, 4'hc, 4'hd: return "R5";
      4'h8: return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    op = 8'h07; d = '0; s = '0; im = '0; of = '0; k = '0; pc = 32'd10;
    // idle state: non-jump class
    apply("R10 idle", 8'h07, 0, 0, 0, 0, 0, 32'd10);
    // R1 / R2 width
    apply("R1 wide ugt", 8'h2d, 64'h1_0000_0000, 64'h1, 0, 16'd4, 0, 32'd50);
    apply("R2 narrow ugt", 8'h2e, 64'h1_0000_0000, 64'h1, 0, 16'd4, 0, 32'd50);
    apply("R2 narrow eq high differ", 8'h1e, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 0, 16'd9, 0, 32'd7);
    // R3
    apply("R3 eq", 8'h1d, 64'd42, 64'd42, 0, 16'd3, 0, 32'd20);
    apply("R3 any zero", 8'h4d, 64'hF0, 64'h0F, 0, 16'd3, 0, 32'd20);
    apply("R3 any set", 8'h4d, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 0, 16'd3, 0, 32'd20);
    apply("R3 ne", 8'h5d, 64'd1, 64'd2, 0, 16'd3, 0, 32'd20);
    // R4
    apply("R4 ult", 8'had, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 16'd5, 0, 32'd30);
    apply("R4 ule eq", 8'hbd, 64'd77, 64'd77, 0, 16'd5, 0, 32'd30);
    apply("R4 uge less", 8'h3d, 64'd3, 64'd4, 0, 16'd5, 0, 32'd30);
    // R5
    apply("R5 sgt neg", 8'h6d, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 16'd6, 0, 32'd40);
    apply("R5 slt neg", 8'hcd, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 16'd6, 0, 32'd40);
    apply("R5 0x7e narrow sge", 8'h7e, 64'h0000_0000_8000_0000, 64'd0, 0, 16'd6, 0, 32'd40);
    apply("R5 0x7d wide sge", 8'h7d, 64'h0000_0000_8000_0000, 64'd0, 0, 16'd6, 0, 32'd40);
    apply("R5 sle narrow", 8'hde, 64'h0000_0001_FFFF_FFFE, 64'h0000_0000_FFFF_FFFE, 0, 16'd6, 0, 32'd40);
    // R6 operand select
    apply("R6 imm sext", 8'h15, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'hFFFF_FFFF, 16'd2, 0, 32'd60);
    apply("R6 imm sext miss", 8'h15, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF, 32'hFFFF_FFFF, 16'd2, 0, 32'd60);
    apply("R6 reg over imm", 8'h1d, 64'd5, 64'd5, 32'd9, 16'd2, 0, 32'd60);
    // R7
    apply("R7 backward", 8'h1d, 64'd0, 64'd0, 0, 16'hFFFD, 0, 32'd100);
    apply("R7 wide ja", 8'h05, 64'd0, 64'd0, 32'd1000, 16'd12, 0, 32'd100);
    // R8
    apply("R8 narrow ja", 8'h06, 64'd0, 64'd0, 32'h10, 16'h7FFF, 0, 32'd100);
    apply("R8 narrow ja neg", 8'h06, 64'd0, 64'd0, 32'hFFFF_FF00, 16'd1, 0, 32'd1000);
    // R9
    apply("R9 local call", 8'h85, 64'd0, 64'd0, 32'hFFFF_FFFB, 16'd3, 4'd1, 32'd200);
    apply("R9 helper call", 8'h85, 64'd0, 64'd0, 32'd77, 16'd3, 4'd0, 32'd200);
    apply("R9 id call", 8'h85, 64'd0, 64'd0, 32'd77, 16'd3, 4'd2, 32'd200);
    // R10
    apply("R10 exit", 8'h95, 64'd0, 64'd0, 0, 16'd3, 0, 32'd300);
    apply("R10 narrow exit", 8'h96, 64'd0, 64'd0, 0, 16'd3, 0, 32'd300);
    apply("R10 narrow call", 8'h86, 64'd0, 64'd0, 32'd5, 16'd3, 4'd1, 32'd300);
    apply("R10 rsv code", 8'he5, 64'd1, 64'd1, 32'd5, 16'd3, 0, 32'd300);
    apply("R10 alu class", 8'h04, 64'd1, 64'd1, 32'd5, 16'd3, 0, 32'd300);
    // R11
    apply("R11 wrap seq", 8'h07, 64'd0, 64'd0, 0, 0, 0, 32'hFFFF_FFFF);
    apply("R11 wrap taken", 8'h1d, 64'd0, 64'd0, 0, 16'd4, 0, 32'hFFFF_FFFE);
    // randomized sweep
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] ro;
      logic [63:0] ra, rb;
      ro = 8'($urandom);
      if ($urandom_range(0, 3) != 0) ro[2:0] = ($urandom_range(0, 1) == 0) ? 3'd5 : 3'd6;
      ra = {$urandom, $urandom};
      rb = ($urandom_range(0, 3) == 0) ? ra : {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) rb[31:0] = ra[31:0];
      apply(tag_of(ro), ro, ra, rb, $urandom, 16'($urandom), 4'($urandom_range(0, 2)), $urandom);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule